// File: doc/BRIEF.md
# Mining Work Loader and Nonce Sequencer

This block sits between a byte-wide serial receive stream, an external hash engine and a byte-wide serial transmit stream. It collects fixed 64-byte work frames with no command or probe before them, keeps the 256-bit midstate and the 96-bit header tail, and drops the 20 padding bytes in between. Each complete frame starts a fresh search at once, even if a search is already running.

The search walks one half of the nonce space. A strap input picks the lower or the upper half. The block offers one candidate at a time to the hash engine over a valid/ready handshake, and the engine answers with a same-cycle hit flag. A hit stops the search and pushes the nonce out, most significant byte first, with no request from the host. If the last nonce of the half is checked without a hit, the search ends quietly with a one-cycle pulse. A busy flag is high for as long as a search runs.

Top module: `mining_work_seq`

## Requirements
- R1: Frame bytes are numbered 0 to 63 in arrival order (one byte per cycle with `rx_valid` high). Bytes 0 to 31 form `work_mid`, with byte 0 in bits [255:248] and byte 31 in bits [7:0].
- R2: Bytes 32 to 51 are padding. Their values have no effect on `work_mid`, on `work_tail` or on the search.
- R3: Bytes 52 to 63 form `work_tail`, with byte 52 in bits [95:88] and byte 63 in bits [7:0].
- R4: `work_mid` and `work_tail` change only on the cycle after byte 63 is taken. That same edge starts a new search even while `busy` is high: `busy` is 1 and `cand_nonce` is the range base on the next cycle.
- R5: `upper_half`, sampled with byte 63, selects the range. With 0 the range is 0 up to 2^(NONCE_W-1)-1. With 1 it is 2^(NONCE_W-1) up to 2^NONCE_W-1. The search starts at the low end of the range.
- R6: `cand_nonce` advances by exactly one after each cycle in which `cand_valid` and `cand_ready` are both high and `hit` is low. It holds while `cand_ready` is low.
- R7: A `hit` in an accepting cycle ends the search: `busy` is 0 on the next cycle, and the accepted nonce is queued for transmission.
- R8: A result leaves as NONCE_W/8 bytes on `tx_data`, most significant first. Each byte stays stable with `tx_valid` high until a cycle in which `tx_ready` is high.
- R9: When the last nonce of the range is accepted without a hit, `busy` drops and `range_done` pulses high for exactly one cycle. No byte is transmitted.
- R10: `cand_valid` is high exactly while `busy` is high. Both are 0 after reset, and `tx_valid` is 0 after reset.
- R11: If IDLE_LIMIT or more consecutive cycles pass without a byte in the middle of a frame, the partial frame is discarded and the next byte counts as byte 0. A gap of IDLE_LIMIT-1 cycles keeps the frame.
- R12: A frame that arrives during a transmission does not alter the bytes being sent. A result found while an earlier one is still being sent is held in a single slot and sent right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` carries a byte this cycle |
| upper_half | input | 1 | Range strap: 0 selects the lower half, 1 the upper half |
| work_mid | output | 256 | Midstate of the current work |
| work_tail | output | 96 | Header tail of the current work |
| cand_valid | output | 1 | A candidate is offered to the engine |
| cand_nonce | output | NONCE_W | Candidate nonce |
| cand_ready | input | 1 | The engine takes the candidate this cycle |
| hit | input | 1 | The candidate taken this cycle meets the target |
| tx_data | output | 8 | Result byte |
| tx_valid | output | 1 | `tx_data` holds a byte to send |
| tx_ready | input | 1 | The serializer takes `tx_data` this cycle |
| busy | output | 1 | A search is running |
| range_done | output | 1 | One-cycle pulse: range finished without a hit |

## Verification
Frames are built from seeds so that every byte has its own value. Two frames that differ only in their padding bytes must give the same work outputs, which separates the padding from the midstate and tail fields. A target near the bottom of the lower half, taken with a stalling `cand_ready`, and a target inside the upper half test advance-on-accept and strap selection. An unreachable target, following a mid-search restart, walks the whole lower half and shows that exhaustion differs from a find. Gaps one cycle short of the idle limit and exactly at it tell keep from discard. Two finds made while the transmit side is stalled show that the pending slot and the byte order are kept.

// File: rtl/mws_pkg.sv
package mws_pkg;

  // Frame layout, in bytes, in arrival order
  localparam int MID_BYTES   = 32;
  localparam int PAD_BYTES   = 20;
  localparam int TAIL_BYTES  = 12;
  localparam int FRAME_BYTES = MID_BYTES + PAD_BYTES + TAIL_BYTES;
  localparam int TAIL_FIRST  = MID_BYTES + PAD_BYTES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int MID_W       = MID_BYTES * 8;
  localparam int TAIL_W      = TAIL_BYTES * 8;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

endpackage

// File: rtl/mws_frame_rx.sv
module mws_frame_rx
  import mws_pkg::*;
#(
  parameter int IDLE_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              frame_done,
  output logic              idle_drop,
  output logic [MID_W-1:0]  mid_work,
  output logic [TAIL_W-1:0] tail_work
);

  localparam int GAP_W = $clog2(IDLE_LIMIT + 1);

  logic [IDX_W-1:0]  idx_q;
  logic [GAP_W-1:0]  gap_q;
  logic [MID_W-1:0]  mid_sh;
  logic [TAIL_W-1:0] tail_sh;

  logic in_mid;
  logic in_tail;
  logic at_last;

  // Field decode from the byte index
  function automatic logic idx_in_mid(input logic [IDX_W-1:0] i);
    return i < IDX_W'(MID_BYTES);
  endfunction

  function automatic logic idx_in_tail(input logic [IDX_W-1:0] i);
    return i >= IDX_W'(TAIL_FIRST);
  endfunction

  assign in_mid     = idx_in_mid(idx_q);
  assign in_tail    = idx_in_tail(idx_q);
  assign at_last    = (idx_q == IDX_W'(FRAME_BYTES - 1));
  assign frame_done = rx_valid && at_last;
  assign idle_drop  = !rx_valid && (idx_q != '0) && (gap_q == GAP_W'(IDLE_LIMIT - 1));

  // Byte index and idle gap counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      gap_q <= '0;
    end else if (rx_valid) begin
      idx_q <= at_last ? '0 : idx_q + 1'b1;
      gap_q <= '0;
    end else if (idle_drop) begin
      idx_q <= '0;
      gap_q <= '0;
    end else if (idx_q != '0) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // Field shift registers: padding bytes are not stored
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_sh  <= '0;
      tail_sh <= '0;
    end else if (rx_valid) begin
      if (in_mid) begin
        mid_sh <= {mid_sh[MID_W-9:0], rx_data};
      end
      if (in_tail) begin
        tail_sh <= {tail_sh[TAIL_W-9:0], rx_data};
      end
    end
  end

  // Work registers, loaded only when a frame completes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_work  <= '0;
      tail_work <= '0;
    end else if (frame_done) begin
      mid_work  <= mid_sh;
      tail_work <= {tail_sh[TAIL_W-9:0], rx_data};
    end
  end

endmodule

// File: rtl/mws_nonce_seq.sv
module mws_nonce_seq
  import mws_pkg::*;
#(
  parameter int NONCE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               upper_half,
  input  logic               cand_ready,
  input  logic               hit,
  output logic               busy,
  output logic [NONCE_W-1:0] cand_nonce,
  output logic               found,
  output logic [NONCE_W-1:0] found_nonce,
  output logic               exhausted
);

  localparam int LOW_W = NONCE_W - 1;

  seq_state_e         state_q;
  logic [NONCE_W-1:0] nonce_q;
  logic               accept;
  logic               at_end;

  // First nonce of the selected half
  function automatic logic [NONCE_W-1:0] range_base(input logic up);
    return {up, {LOW_W{1'b0}}};
  endfunction

  // Last nonce of a half: all bits below the half select are ones
  function automatic logic range_end(input logic [NONCE_W-1:0] n);
    return &n[LOW_W-1:0];
  endfunction

  assign busy       = (state_q == SEQ_RUN);
  assign cand_nonce = nonce_q;
  assign accept     = busy && cand_ready;
  assign at_end     = range_end(nonce_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      nonce_q     <= '0;
      found       <= 1'b0;
      found_nonce <= '0;
      exhausted   <= 1'b0;
    end else begin
      found     <= 1'b0;
      exhausted <= 1'b0;
      if (start) begin
        state_q <= SEQ_RUN;
        nonce_q <= range_base(upper_half);
      end else if (accept) begin
        if (hit) begin
          state_q     <= SEQ_IDLE;
          found       <= 1'b1;
          found_nonce <= nonce_q;
        end else if (at_end) begin
          state_q   <= SEQ_IDLE;
          exhausted <= 1'b1;
        end else begin
          nonce_q <= nonce_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mws_result_tx.sv
module mws_result_tx
  import mws_pkg::*;
#(
  parameter int NONCE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               found,
  input  logic [NONCE_W-1:0] found_nonce,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_valid
);

  localparam int RES_BYTES = NONCE_W / 8;
  localparam int LEFT_W    = $clog2(RES_BYTES + 1);

  tx_state_e          state_q;
  logic [NONCE_W-1:0] sh_q;
  logic [LEFT_W-1:0]  left_q;
  logic               pend_q;
  logic [NONCE_W-1:0] pend_val_q;
  logic               fire;
  logic               last_fire;

  // Most significant byte of the shift register is on the wire
  function automatic logic [7:0] top_byte(input logic [NONCE_W-1:0] v);
    return v[NONCE_W-1 -: 8];
  endfunction

  assign tx_valid  = (state_q == TX_SEND);
  assign tx_data   = top_byte(sh_q);
  assign fire      = tx_valid && tx_ready;
  assign last_fire = fire && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      sh_q       <= '0;
      left_q     <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (state_q == TX_IDLE) begin
      if (found) begin
        state_q <= TX_SEND;
        sh_q    <= found_nonce;
        left_q  <= LEFT_W'(RES_BYTES - 1);
      end
    end else if (last_fire) begin
      if (pend_q) begin
        sh_q   <= pend_val_q;
        left_q <= LEFT_W'(RES_BYTES - 1);
        pend_q <= found;
        if (found) begin
          pend_val_q <= found_nonce;
        end
      end else if (found) begin
        sh_q   <= found_nonce;
        left_q <= LEFT_W'(RES_BYTES - 1);
      end else begin
        state_q <= TX_IDLE;
      end
    end else begin
      if (fire) begin
        sh_q   <= sh_q << 8;
        left_q <= left_q - 1'b1;
      end
      if (found) begin
        pend_q     <= 1'b1;
        pend_val_q <= found_nonce;
      end
    end
  end

endmodule

// File: rtl/mining_work_seq.sv
module mining_work_seq
  import mws_pkg::*;
#(
  parameter int NONCE_W    = 32,
  parameter int IDLE_LIMIT = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         rx_data,
  input  logic               rx_valid,
  input  logic               upper_half,
  output logic [MID_W-1:0]   work_mid,
  output logic [TAIL_W-1:0]  work_tail,
  output logic               cand_valid,
  output logic [NONCE_W-1:0] cand_nonce,
  input  logic               cand_ready,
  input  logic               hit,
  output logic [7:0]         tx_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic               busy,
  output logic               range_done
);

  // Named internal events, visible to the bound checker
  logic               pkt_done;
  logic               pkt_drop;
  logic               found_pulse;
  logic [NONCE_W-1:0] found_val;
  logic               seq_busy;

  mws_frame_rx #(
    .IDLE_LIMIT(IDLE_LIMIT)
  ) frame_rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_done(pkt_done),
    .idle_drop (pkt_drop),
    .mid_work  (work_mid),
    .tail_work (work_tail)
  );

  mws_nonce_seq #(
    .NONCE_W(NONCE_W)
  ) nonce_seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (pkt_done),
    .upper_half (upper_half),
    .cand_ready (cand_ready),
    .hit        (hit),
    .busy       (seq_busy),
    .cand_nonce (cand_nonce),
    .found      (found_pulse),
    .found_nonce(found_val),
    .exhausted  (range_done)
  );

  mws_result_tx #(
    .NONCE_W(NONCE_W)
  ) result_tx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .found      (found_pulse),
    .found_nonce(found_val),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid)
  );

  assign busy       = seq_busy;
  assign cand_valid = seq_busy;

endmodule

// File: rtl/mining_work_seq_chk.sv
module mining_work_seq_chk #(
  parameter int NONCE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_done,
  input logic               upper_half,
  input logic               busy,
  input logic               cand_ready,
  input logic               hit,
  input logic [NONCE_W-1:0] cand_nonce,
  input logic               range_done,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [7:0]         tx_data
);

  logic at_top;
  assign at_top = &cand_nonce[NONCE_W-2:0];

  a_r4_restart_base: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> busy && (cand_nonce == {$past(upper_half), {(NONCE_W-1){1'b0}}}));

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cand_ready && !pkt_done |=> $stable(cand_nonce));

  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cand_ready && !hit && !pkt_done && !at_top |=> busy && (cand_nonce == $past(cand_nonce) + 1'b1));

  a_r7_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cand_ready && hit && !pkt_done |=> !busy && !range_done);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    range_done |=> !range_done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    range_done |-> !busy);

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

endmodule

bind mining_work_seq mining_work_seq_chk #(
  .NONCE_W(NONCE_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_done  (pkt_done),
  .upper_half(upper_half),
  .busy      (busy),
  .cand_ready(cand_ready),
  .hit       (hit),
  .cand_nonce(cand_nonce),
  .range_done(range_done),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data)
);

// File: tb/mining_work_seq_tb_top.sv
module mining_work_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NW         = 16;
  localparam int IDLE_LIM   = 256;
  localparam int MAX_CYC    = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_valid = 1'b0;
  logic          upper_half = 1'b0;
  logic [255:0]  work_mid;
  logic [95:0]   work_tail;
  logic          cand_valid;
  logic [NW-1:0] cand_nonce;
  logic          cand_ready = 1'b1;
  logic          hit;
  logic [7:0]    tx_data;
  logic          tx_valid;
  logic          tx_ready = 1'b1;
  logic          busy;
  logic          range_done;

  logic [NW-1:0] target = '0;
  logic          stall_en = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  // Monitors
  int            acc_cnt = 0;
  logic [NW-1:0] last_acc = '0;
  int            seq_err = 0;
  int            done_cnt = 0;
  int            done_wide = 0;
  logic          prev_done = 1'b0;
  logic [7:0]    got [0:63];
  int            nbytes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Engine model: a plain comparator
  assign hit = cand_valid && (cand_nonce == target);

  mining_work_seq #(
    .NONCE_W(NW),
    .IDLE_LIMIT(IDLE_LIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .upper_half(upper_half), .work_mid(work_mid), .work_tail(work_tail),
    .cand_valid(cand_valid), .cand_nonce(cand_nonce), .cand_ready(cand_ready),
    .hit(hit), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .busy(busy), .range_done(range_done)
  );

  // Engine ready pattern
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cand_ready = stall_en ? ~cand_ready : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (cand_valid && cand_ready) begin
      if (acc_cnt > 0 && cand_nonce != last_acc + 1'b1) seq_err++;
      last_acc = cand_nonce;
      acc_cnt++;
    end
    if (range_done) begin
      done_cnt++;
      if (prev_done) done_wide++;
    end
    prev_done = range_done;
    if (tx_valid && tx_ready && nbytes < 64) begin
      got[nbytes] = tx_data;
      nbytes++;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int fseed, input int k);
    int s;
    s = (k >= 32 && k < 52) ? fseed : seed;
    return 8'((s * 37 + k * 11) ^ 8'h5A);
  endfunction

  function automatic logic [255:0] exp_mid(input int seed);
    logic [255:0] m = '0;
    for (int k = 0; k < 32; k++) m = {m[247:0], byte_of(seed, 0, k)};
    return m;
  endfunction

  function automatic logic [95:0] exp_tail(input int seed);
    logic [95:0] t = '0;
    for (int k = 52; k < 64; k++) t = {t[87:0], byte_of(seed, 0, k)};
    return t;
  endfunction

  task automatic send_bytes(input int seed, input int fseed, input int first, input int last);
    for (int k = first; k <= last; k++) begin
      rx_data  = byte_of(seed, fseed, k);
      rx_valid = 1'b1;
      @(posedge clk);
      #1;
    end
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input int seed, input int fseed);
    send_bytes(seed, fseed, 0, 63);
    acc_cnt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    while (busy) @(posedge clk);
    #1;
  endtask

  task automatic wait_bytes(input int n);
    while (nbytes < n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R10 busy in reset", 256'(busy), 256'(0));
    check("R10 cand_valid in reset", 256'(cand_valid), 256'(0));
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R10 busy after reset", 256'(busy), 256'(0));
    check("R10 tx_valid after reset", 256'(tx_valid), 256'(0));
  endtask

  task automatic t_fields_and_padding();
    nbytes = 0;
    upper_half = 1'b0;
    target = 16'h0000;
    send_frame(5, 1);
    check("R1 midstate", work_mid, exp_mid(5));
    check("R3 tail", 256'(work_tail), 256'(exp_tail(5)));
    check("R10 cand_valid with busy", 256'({busy, cand_valid}), 256'(2'b11));
    wait_idle();
    wait_bytes(2);
    send_frame(9, 1);
    wait_idle();
    wait_bytes(4);
    send_frame(5, 200);
    check("R2 padding ignored mid", work_mid, exp_mid(5));
    check("R2 padding ignored tail", 256'(work_tail), 256'(exp_tail(5)));
    wait_idle();
    wait_bytes(6);
    check("R2 padding no effect on result", 256'({got[4], got[5]}), 256'(16'h0000));
    idle(4);
  endtask

  task automatic t_found_low_stall();
    nbytes = 0;
    upper_half = 1'b0;
    target = 16'h0123;
    stall_en = 1'b1;
    send_frame(11, 3);
    check("R5 lower base", 256'(cand_nonce), 256'(16'h0000));
    check("R4 busy after load", 256'(busy), 256'(1));
    wait_idle();
    stall_en = 1'b0;
    check("R6 accepted count", 256'(acc_cnt), 256'(32'h124));
    check("R6 sequence gaps", 256'(seq_err), 256'(0));
    check("R7 last accepted is target", 256'(last_acc), 256'(16'h0123));
    wait_bytes(2);
    check("R8 result bytes msb first", 256'({got[0], got[1]}), 256'(16'h0123));
    check("R9 no done pulse on find", 256'(done_cnt), 256'(0));
    idle(4);
  endtask

  task automatic t_found_upper();
    nbytes = 0;
    upper_half = 1'b1;
    target = 16'h8005;
    send_frame(21, 4);
    upper_half = 1'b0;
    check("R5 upper base", 256'(cand_nonce), 256'(16'h8000));
    wait_idle();
    wait_bytes(2);
    check("R5 upper result", 256'({got[0], got[1]}), 256'(16'h8005));
    check("R7 upper accepted count", 256'(acc_cnt), 256'(6));
    idle(4);
  endtask

  task automatic t_restart_and_exhaust();
    int d0;
    nbytes = 0;
    d0 = done_cnt;
    upper_half = 1'b0;
    target = 16'hF000;
    send_frame(31, 2);
    idle(100);
    check("R10 busy during search", 256'(busy), 256'(1));
    send_bytes(32, 2, 0, 62);
    check("R4 work held before last byte", work_mid, exp_mid(31));
    send_bytes(32, 2, 63, 63);
    acc_cnt = 0;
    check("R4 restart loads new work", work_mid, exp_mid(32));
    check("R4 restart at base", 256'(cand_nonce), 256'(16'h0000));
    check("R4 still busy after restart", 256'(busy), 256'(1));
    wait_idle();
    idle(3);
    check("R9 done pulse count", 256'(done_cnt - d0), 256'(1));
    check("R9 done pulse width", 256'(done_wide), 256'(0));
    check("R9 last nonce checked", 256'(last_acc), 256'(16'h7FFF));
    check("R9 whole range walked", 256'(acc_cnt), 256'(32768));
    check("R9 no bytes sent", 256'(nbytes), 256'(0));
    check("R6 exhaust sequence gaps", 256'(seq_err), 256'(0));
  endtask

  task automatic t_idle_timeout();
    send_bytes(41, 1, 0, 9);
    idle(IDLE_LIM);
    target = 16'h0002;
    send_frame(42, 1);
    check("R11 partial frame dropped", work_mid, exp_mid(42));
    wait_idle();
    wait_bytes(2);
    idle(4);
    send_bytes(43, 1, 0, 9);
    idle(IDLE_LIM - 1);
    send_bytes(43, 1, 10, 63);
    check("R11 short gap keeps frame", work_mid, exp_mid(43));
    check("R11 short gap tail", 256'(work_tail), 256'(exp_tail(43)));
    wait_idle();
    wait_bytes(4);
    idle(4);
  endtask

  task automatic t_pending_tx();
    nbytes = 0;
    tx_ready = 1'b0;
    upper_half = 1'b0;
    target = 16'h0010;
    send_frame(51, 1);
    wait_idle();
    idle(2);
    check("R8 held byte while stalled", 256'({tx_valid, tx_data}), 256'(9'h100));
    target = 16'h0020;
    send_frame(52, 1);
    wait_idle();
    idle(2);
    tx_ready = 1'b1;
    wait_bytes(4);
    check("R12 first result intact", 256'({got[0], got[1]}), 256'(16'h0010));
    check("R12 pending result follows", 256'({got[2], got[3]}), 256'(16'h0020));
    idle(4);
    check("R12 nothing extra sent", 256'(nbytes), 256'(4));
  endtask

  initial begin
    t_reset();
    t_fields_and_padding();
    t_found_low_stall();
    t_found_upper();
    t_restart_and_exhaust();
    t_idle_timeout();
    t_pending_tx();
    summary();
    $finish;
  end

endmodule